// File: doc/BRIEF.md
# SMBus Byte-Register Slave

This block is an SMBus target that lets a host reach a bank of eight byte-wide registers over the two-wire bus. The upper four bits of its 7-bit address are fixed. The lower three bits come from strap pins, which are sampled once on the first clock after reset. Both bus lines are oversampled by the block's own clock through synchronisers. Start and stop conditions are found as SDA edges while SCL is high, and the block walks a small phase machine through address, command, write-data and read phases.

The command byte selects a register and stays in a pointer register until a later valid command replaces it. This gives three transfer shapes:
- a write transfer (address, command, data);
- a combined read (address, command, repeated start, address with read bit, data);
- a bare read (address with read bit, data), which returns whatever register the pointer last selected.

A local port beside the bus lets the surrounding logic read and write the same registers. Every local access is taken at once and nothing applies back-pressure. The bus lines are modelled as open-drain: the block never drives a high level, it only asserts an output enable that pulls the line low.

Top module: `smb_byte_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {1000b, strap} (bit 0 is the direction, 1 = read, 0 = write). Any other address is not acknowledged, and the rest of that transfer is ignored until the next start condition.
- R2: The strap value is captured on the first clock edge after reset is released. Later changes on the strap pins have no effect on the address.
- R3: In a write transfer, the data byte is written to the register selected by the command byte's low three bits. Address, command and data are each acknowledged.
- R4: In a combined read, the slave returns the register named by the command byte after the repeated start and the read address.
- R5: A bare read with no command byte returns the register held in the pointer from the most recent valid command.
- R6: A command byte with any of bits 7..3 set is reserved. It is not acknowledged, it leaves the pointer unchanged, and the data byte that follows is neither acknowledged nor written.
- R7: Bytes that follow the single data byte of a write transfer are not acknowledged and write nothing.
- R8: During a read, if the master acknowledges, the same register is sent again. If the master does not acknowledge, SDA is released and stays released.
- R9: A start or stop condition in the middle of a byte abandons that byte. Nothing is written and the pointer keeps its last valid value.
- R10: The local port reads any register combinationally and writes it on a clock edge when its write enable is high. If a bus write and a local write land on the same cycle, the bus write wins.
- R11: The SDA output enable only turns on while SCL is low. SCL is never driven (its output enable stays 0).
- R12: After reset, SDA is released, every register reads 0 and the pointer selects register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull-down enable for SCL, always 0 |
| sda_oe | output | 1 | Pull-down enable for SDA (1 = drive low) |
| strap_i | input | 3 | Address low bits, captured once after reset |
| lcl_we | input | 1 | Local write enable |
| lcl_addr | input | 3 | Local register index |
| lcl_wdata | input | 8 | Local write data |
| lcl_rdata | output | 8 | Register contents at lcl_addr |

## Verification
The assertions assume the following of the bus master:
- SDA changes only while SCL is low, except when forming a start or stop condition.
- Each SCL high and low phase lasts well beyond the synchroniser and edge-detect latency of about four clocks.

The bench's master model keeps to this. Every SCL quarter-phase lasts eight clocks, and SDA is moved only in the middle of a low phase or deliberately during a high phase for start and stop. A stop is forced only after the slave has released the line. The random mix stays within legal transfers, with a sprinkling of reserved command codes, and the directed cases supply the wrong-address, extra-byte, master-acknowledge and mid-byte abort patterns.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_READ
  } smb_phase_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_p;
  logic              sda_p;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain[g] <= 1'b1;
          sda_chain[g] <= 1'b1;
        end else begin
          scl_chain[g] <= scl_i;
          sda_chain[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain[g] <= 1'b1;
          sda_chain[g] <= 1'b1;
        end else begin
          scl_chain[g] <= scl_chain[g-1];
          sda_chain[g] <= sda_chain[g-1];
        end
      end
    end
  end

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_strap_latch.sv
module smb_strap_latch #(
  parameter int         STRAP_W  = 3,
  parameter logic [6:0] DEV_BASE = 7'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [6:0]         dev_addr
);
  logic               captured;
  logic [STRAP_W-1:0] addr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      addr_lo  <= '0;
    end else if (!captured) begin
      captured <= 1'b1;
      addr_lo  <= strap_i;
    end
  end

  assign dev_addr = {DEV_BASE[6:STRAP_W], addr_lo};

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> ($stable(addr_lo) && captured)); // R2
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [PW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          lcl_we,
  input  logic [PW-1:0] lcl_addr,
  input  logic [DW-1:0] lcl_wdata,
  output logic [DW-1:0] lcl_rdata
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end else if (lcl_we) begin
      mem[lcl_addr] <= lcl_wdata;
    end
  end

  assign bus_rdata = mem[bus_addr];
  assign lcl_rdata = mem[lcl_addr];

  AST_BUS_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (mem[$past(bus_addr)] == $past(bus_wdata))); // R10
endmodule

// File: rtl/smb_protocol.sv
module smb_protocol
  import smb_pkg::*;
#(
  parameter int NREG = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PW-1:0]     ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [3:0] BIT_LAST = 4'd7;
  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_END  = 4'd9;

  smb_phase_e        phase;
  smb_phase_e        nxt_q;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              ack_q;
  logic              mack_q;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      nxt_q   <= PH_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      ack_q   <= 1'b0;
      mack_q  <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (phase != PH_READ) begin
            if (cnt < BIT_ACK) shreg <= byte_in;
            if (cnt == BIT_LAST) begin
              unique case (phase)
                PH_ADDR: begin
                  if (byte_in[BYTE_W-1:1] == dev_addr) begin
                    ack_q <= 1'b1;
                    nxt_q <= byte_in[0] ? PH_READ : PH_CMD;
                  end else begin
                    ack_q <= 1'b0;
                    nxt_q <= PH_IDLE;
                  end
                end
                PH_CMD: begin
                  if (byte_in[BYTE_W-1:PW] == '0) begin
                    ack_q <= 1'b1;
                    ptr   <= byte_in[PW-1:0];
                    nxt_q <= PH_WDATA;
                  end else begin
                    ack_q <= 1'b0;
                    nxt_q <= PH_IDLE;
                  end
                end
                PH_WDATA: begin
                  ack_q   <= 1'b1;
                  wr_en   <= 1'b1;
                  wr_data <= byte_in;
                  nxt_q   <= PH_IDLE;
                end
                default: begin
                  ack_q <= 1'b0;
                  nxt_q <= PH_IDLE;
                end
              endcase
            end
          end else if (cnt == BIT_ACK) begin
            mack_q <= ~sda_s;
          end
        end else if (scl_fall) begin
          if (phase != PH_READ) begin
            if (cnt == BIT_ACK) begin
              sda_oe <= ack_q;
            end else if (cnt == BIT_END) begin
              cnt   <= '0;
              phase <= nxt_q;
              if (nxt_q == PH_READ) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end else begin
            if (cnt >= 4'd1 && cnt <= BIT_LAST) begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
            end else if (cnt == BIT_ACK) begin
              sda_oe <= 1'b0;
            end else if (cnt == BIT_END) begin
              cnt <= '0;
              if (mack_q) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11
  AST_PTR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> ($past(phase) == PH_CMD)); // R6
  AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (phase == PH_WDATA)); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe); // R1
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == PH_ADDR && cnt == 4'd0 && !sda_oe && !wr_en)); // R9
endmodule

// File: rtl/smb_byte_slave.sv
module smb_byte_slave
  import smb_pkg::*;
#(
  parameter int         NREG        = 8,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_BASE    = 7'h40,
  localparam int        PW          = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               scl_oe,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               lcl_we,
  input  logic [PW-1:0]      lcl_addr,
  input  logic [BYTE_W-1:0]  lcl_wdata,
  output logic [BYTE_W-1:0]  lcl_rdata
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] dev_addr;
  logic [PW-1:0]     ptr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;

  assign scl_oe = 1'b0;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_strap_latch #(.STRAP_W(STRAP_W), .DEV_BASE(DEV_BASE)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .dev_addr(dev_addr)
  );

  smb_protocol #(.NREG(NREG)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smb_regfile #(.NREG(NREG), .DW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(wr_en), .bus_addr(ptr), .bus_wdata(wr_data), .bus_rdata(rd_data),
    .lcl_we(lcl_we), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata)
  );

  AST_SCL_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> !scl_oe); // R11
endmodule

// File: tb/tb_smb_byte_slave.sv
module tb_smb_byte_slave;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       lcl_we = 1'b0;
  logic [2:0] lcl_addr = '0;
  logic [7:0] lcl_wdata = '0;
  logic [7:0] lcl_rdata;
  logic       scl_oe, sda_oe;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0;

  logic [7:0] mdl [8];
  logic [2:0] mptr;
  logic [6:0] my_addr = 7'h45;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smb_byte_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m & ~scl_oe), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .strap_i(strap),
    .lcl_we(lcl_we), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata)
  );

  // R11 monitor: enable must never turn on while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !prev_oe && scl_m) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); ack = ~sda_line; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b[i] = sda_line; hq(); scl_m = 1'b0; hq();
    end
    sda_m = ~mack; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    sda_m = 1'b1;
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                         output bit [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic rd_xfer(input logic [7:0] cmd, output bit cack, output logic [7:0] d);
    bit a0, a1;
    bus_start();
    send_byte({my_addr, 1'b0}, a0);
    send_byte(cmd, cack);
    bus_start();
    send_byte({my_addr, 1'b1}, a1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic rcv_xfer(output bit aack, output logic [7:0] d);
    bus_start();
    send_byte({my_addr, 1'b1}, aack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic lread(input logic [2:0] a, output logic [7:0] d);
    lcl_addr = a; @(negedge clk); d = lcl_rdata;
  endtask

  task automatic lwrite(input logic [2:0] a, input logic [7:0] d);
    lcl_addr = a; lcl_wdata = d; lcl_we = 1'b1; @(negedge clk); lcl_we = 1'b0;
  endtask

  function automatic bit [2:0] exp_wr_acks(input logic [7:0] cmd);
    return (cmd[7:3] == 5'd0) ? 3'b111 : 3'b100;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (all) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [2:0] acks;
    bit ak, ak2;
    logic [7:0] d, d2;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mptr = 3'd0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R12 lines released after reset", sda_oe, 0);
    for (int i = 0; i < 8; i++) begin
      lread(3'(i), d);
      chk(d == 8'h00, "R12 register zero after reset", d, 0);
    end
    repeat (3) @(negedge clk);
    strap = 3'b010;   // R2: late change must not move the address
    hq();

    rcv_xfer(ak, d);
    chk(ak == 1'b1, "R1 own address acked", ak, 1);
    chk(d == 8'h00, "R12 pointer selects reg 0 after reset", d, 0);

    // R2 / R1: the address of the new strap value is not ours
    wr_xfer(7'h42, 8'h00, 8'h77, acks);
    chk(acks == 3'b000, "R2 late strap ignored, foreign address not acked", acks, 0);
    lread(3'd0, d);
    chk(d == 8'h00, "R1 foreign transfer wrote nothing", d, 0);

    // R3 write
    wr_xfer(my_addr, 8'h05, 8'hA5, acks);
    mdl[5] = 8'hA5; mptr = 3'd5;
    chk(acks == 3'b111, "R3 write acks", acks, 7);
    lread(3'd5, d);
    chk(d == 8'hA5, "R3 written value", d, 8'hA5);

    // R4 combined read, R5 bare read
    wr_xfer(my_addr, 8'h02, 8'h3C, acks);
    mdl[2] = 8'h3C; mptr = 3'd2;
    rd_xfer(8'h05, ak, d);
    mptr = 3'd5;
    chk(ak && d == 8'hA5, "R4 combined read data", d, 8'hA5);
    rcv_xfer(ak, d);
    chk(d == 8'hA5, "R5 bare read follows pointer", d, 8'hA5);

    // R6 reserved command
    wr_xfer(my_addr, 8'h09, 8'hEE, acks);
    chk(acks == 3'b100, "R6 reserved command acks", acks, 4);
    lread(3'd1, d);
    chk(d == 8'h00, "R6 reserved command wrote nothing", d, 0);
    rcv_xfer(ak, d);
    chk(d == 8'hA5, "R6 pointer unchanged", d, 8'hA5);

    // R7 extra bytes
    bus_start();
    send_byte({my_addr, 1'b0}, ak);
    send_byte(8'h04, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak2);
    bus_stop();
    mdl[4] = 8'h11; mptr = 3'd4;
    chk(ak2 == 1'b0, "R7 extra byte not acked", ak2, 0);
    lread(3'd4, d);
    chk(d == 8'h11, "R7 extra byte not written", d, 8'h11);

    // R8 master ack repeats, nack releases
    bus_start();
    send_byte({my_addr, 1'b1}, ak);
    recv_byte(1'b1, d);
    recv_byte(1'b0, d2);
    hq();
    chk(d == 8'h11 && d2 == 8'h11, "R8 repeated register on master ack", d2, 8'h11);
    chk(sda_oe == 1'b0, "R8 released after master nack", sda_oe, 0);
    bus_stop();

    // R9 abort mid data byte by stop
    wr_xfer(my_addr, 8'h03, 8'h5A, acks);
    mdl[3] = 8'h5A; mptr = 3'd3;
    bus_start();
    send_byte({my_addr, 1'b0}, ak);
    send_byte(8'h03, ak);
    send_bits(8'hFF, 4);
    bus_stop();
    lread(3'd3, d);
    chk(d == 8'h5A, "R9 partial data byte not written", d, 8'h5A);
    // R9 abort mid command byte by repeated start
    bus_start();
    send_byte({my_addr, 1'b0}, ak);
    send_bits(8'h06, 4);
    bus_start();
    send_byte({my_addr, 1'b1}, ak);
    recv_byte(1'b0, d);
    bus_stop();
    chk(ak && d == 8'h5A, "R9 pointer kept after aborted command", d, 8'h5A);

    // R10 local write visible on bus
    lwrite(3'd6, 8'hC3);
    mdl[6] = 8'hC3;
    rd_xfer(8'h06, ak, d);
    mptr = 3'd6;
    chk(d == 8'hC3, "R10 local write read over bus", d, 8'hC3);

    // Random mix
    for (int it = 0; it < 45; it++) begin
      int op;
      logic [2:0] r;
      logic [7:0] cmd, dat;
      op  = $urandom_range(0, 3);
      r   = 3'($urandom_range(0, 7));
      dat = 8'($urandom_range(0, 255));
      cmd = ($urandom_range(0, 4) == 0) ? {5'($urandom_range(1, 31)), r} : {5'd0, r};
      case (op)
        0: begin
          wr_xfer(my_addr, cmd, dat, acks);
          if (cmd[7:3] == 5'd0) begin mdl[r] = dat; mptr = r; end
          chk(acks == exp_wr_acks(cmd), "R3 R6 random write acks", acks, exp_wr_acks(cmd));
          lread(r, d);
          chk(d == mdl[r], "R3 R6 random write contents", d, mdl[r]);
        end
        1: begin
          rd_xfer(cmd, ak, d);
          if (cmd[7:3] == 5'd0) mptr = r;
          chk(d == mdl[mptr], "R4 R6 random combined read", d, mdl[mptr]);
        end
        2: begin
          rcv_xfer(ak, d);
          chk(d == mdl[mptr], "R5 random bare read", d, mdl[mptr]);
        end
        default: begin
          lwrite(r, dat);
          mdl[r] = dat;
          lread(r, d);
          chk(d == dat, "R10 random local access", d, dat);
        end
      endcase
    end

    chk(oe_viol == 0, "R11 SDA enable rose while SCL high", oe_viol, 0);
    chk(scl_oe == 1'b0, "R11 SCL never driven", scl_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule